// File: doc/BRIEF.md
# MDIO Station Management Master

This block is the MAC-side manager of a two-wire PHY management bus. It divides the system clock down to a free-running management clock, turns single read or write requests into serial management frames, and releases the data line whenever the PHY must talk or the bus is idle. Outgoing bits change on the falling edge of the management clock, and incoming bits are captured on the rising edge.

When reset ends, the master handles the bus by itself before it accepts any user request. It sends a 32-bit run of ones, which the PHY needs once after reset, and then reads status register 1 from the PHY address on `init_phy`. Bit 6 of that register says whether the PHY accepts frames without a leading run of ones. If that bit reads 1 and the read had a valid turnaround, every later frame starts directly with the start bits. If not, every later frame is again preceded by 32 ones. Each frame is always followed by at least one released idle bit.

A user request is a single-cycle `req_valid` that arrives while `busy` is low. It carries a direction flag, a PHY address, a register address and write data. When the transaction is complete, `done` pulses for one cycle. A read returns its data on `rd_data`, and `rd_err` reports a PHY that failed to drive the turnaround low.

Top module: `mdio_mgmt_master`

## Requirements
- R1: `mdc` toggles every `CLK_DIV` system clocks (CLK_DIV of at least 2) and runs continuously. `mdio_o` and `mdio_oe` change only in the cycle in which `mdc` falls.
- R2: A frame is sent MSB first as: start `01`, opcode (`10` read, `01` write), 5-bit PHY address, 5-bit register address, 2 turnaround bits, 16 data bits.
- R3: In a write frame the master drives the turnaround as `10` and then the 16 data bits. In a read frame `mdio_oe` is low from the first turnaround bit to the end of the frame.
- R4: In a read frame the 16 bits sampled at the `mdc` rising edges of the data field appear on `rd_data` when `done` pulses high for exactly one cycle.
- R5: If the second turnaround bit of a read is not 0, `rd_err` is 1 with `done`. For a write or a valid read, `rd_err` is 0.
- R6: During reset and right after it, `busy` is 1, `mdio_oe` is 0 and `done` is 0. The master sends 32 ones and then a read of register 1 at `init_phy`. This sequence raises no `done`.
- R7: After the start-up read, every later frame has no leading ones if bit 6 of that read was 1 and its turnaround was valid. Otherwise every later frame has exactly 32 leading ones.
- R8: Consecutive frames are separated by at least one bit time with `mdio_oe` low. `busy` stays high until that idle bit has ended.
- R9: A `req_valid` that arrives while `busy` is high is ignored: it produces no frame and no register change.
- R10: `done` follows request acceptance within (P+33)·2·CLK_DIV+1 to (P+34)·2·CLK_DIV+1 clocks, where P is the number of leading ones (32 or 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_phy | input | 5 | PHY address used for the start-up status read |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Data for a write |
| busy | output | 1 | High from reset or acceptance until the idle bit after the frame |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read data, valid with done |
| rd_err | output | 1 | Turnaround error, valid with done |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven onto the bus |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Bus value (pulled high when released) |

## Verification
Each result is due at a cycle that can be computed. A frame bit lasts 2·CLK_DIV clocks. `done` arrives one clock after the falling `mdc` edge that ends the idle bit, so with a preamble of P ones it lands within one bit time of (P+33) bit times after acceptance. The bench counts clocks from the request to `done` and checks that count against this window. It then samples `rd_data` and `rd_err` on the same falling system-clock edge at which it sees `done`. The behavioural PHY looks at the bus one half system clock after each `mdc` rise, when the master has already sampled it. It changes its own drive only at that point, so every value stays stable for a full bit before the next capture.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int CLK_DIV = 2,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  init_phy,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        rd_err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int DIVW = $clog2(CLK_DIV + 1);
  localparam int CW   = $clog2((PRE_LEN > 32) ? PRE_LEN : 32);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_FRM, S_GAP} st_t;

  st_t             st;
  logic [DIVW-1:0] dcnt;
  logic            mdc_r;
  logic [CW-1:0]   cnt;
  logic [30:0]     sh;
  logic            pend, is_init, pre_off, op_wr, ta_bad;
  logic [4:0]      phy_l, reg_l;
  logic [15:0]     wd_l, rd_sh;
  logic            done_r, err_r, o_r, oe_r;
  logic [31:0]     frame_w;

  wire tick    = (dcnt == DIVW'(CLK_DIV - 1));
  wire fall_ev = tick & mdc_r;
  wire rise_ev = tick & ~mdc_r;
  wire [4:0] phy_sel = is_init ? init_phy : phy_l;

  assign frame_w = {2'b01, op_wr ? 2'b01 : 2'b10, phy_sel, reg_l,
                    op_wr ? 2'b10 : 2'b00, op_wr ? wd_l : 16'h0000};

  assign busy    = pend | (st != S_IDLE);
  assign done    = done_r;
  assign rd_err  = err_r;
  assign rd_data = rd_sh;
  assign mdc     = mdc_r;
  assign mdio_o  = o_r;
  assign mdio_oe = oe_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt  <= '0;
      mdc_r <= 1'b0;
    end else if (tick) begin
      dcnt  <= '0;
      mdc_r <= ~mdc_r;
    end else begin
      dcnt  <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      pend    <= 1'b1;
      is_init <= 1'b1;
      pre_off <= 1'b0;
      op_wr   <= 1'b0;
      ta_bad  <= 1'b0;
      phy_l   <= '0;
      reg_l   <= 5'd1;
      wd_l    <= '0;
      rd_sh   <= '0;
      done_r  <= 1'b0;
      err_r   <= 1'b0;
      o_r     <= 1'b0;
      oe_r    <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (req_valid && !busy) begin
        pend    <= 1'b1;
        is_init <= 1'b0;
        op_wr   <= req_write;
        phy_l   <= req_phy;
        reg_l   <= req_reg;
        wd_l    <= req_wdata;
      end
      if (rise_ev && st == S_FRM && !op_wr) begin
        if (cnt == CW'(15)) ta_bad <= mdio_i;
        if (cnt >= CW'(16)) rd_sh <= {rd_sh[14:0], mdio_i};
      end
      if (fall_ev) begin
        case (st)
          S_IDLE: if (pend) begin
            pend <= 1'b0;
            cnt  <= '0;
            oe_r <= 1'b1;
            if (is_init || !pre_off) begin
              st  <= S_PRE;
              o_r <= 1'b1;
            end else begin
              st  <= S_FRM;
              o_r <= frame_w[31];
              sh  <= frame_w[30:0];
            end
          end
          S_PRE: begin
            if (cnt == CW'(PRE_LEN - 1)) begin
              st  <= S_FRM;
              cnt <= '0;
              o_r <= frame_w[31];
              sh  <= frame_w[30:0];
            end else begin
              cnt <= cnt + 1'b1;
              o_r <= 1'b1;
            end
          end
          S_FRM: begin
            if (cnt == CW'(31)) begin
              st   <= S_GAP;
              oe_r <= 1'b0;
              o_r  <= 1'b0;
            end else begin
              cnt  <= cnt + 1'b1;
              o_r  <= sh[30];
              sh   <= {sh[29:0], 1'b0};
              oe_r <= op_wr || (cnt < CW'(13));
            end
          end
          S_GAP: begin
            st <= S_IDLE;
            if (is_init) begin
              pre_off <= rd_sh[6] & ~ta_bad;
            end else begin
              done_r <= 1'b1;
              err_r  <= ~op_wr & ta_bad;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic rd_err,
  input logic req_valid,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);

  a_r1_bus_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> $fell(mdc));

  a_r1_mdc_min_half: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc) |=> $stable(mdc));

  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_err) |-> done);

  a_r8_released_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  a_r9_busy_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_err(rd_err),
  .req_valid(req_valid), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  localparam int CLK_DIV = 2;
  localparam int BIT_T   = 2 * CLK_DIV;
  localparam logic [4:0] MYPHY = 5'h0C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] init_phy = MYPHY;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = MYPHY, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, rd_err, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rd_data;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  mdio_mgmt_master #(.CLK_DIV(CLK_DIV), .PRE_LEN(32)) uut (
    .clk(clk), .rst_n(rst_n), .init_phy(init_phy), .req_valid(req_valid),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .rd_err(rd_err), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  // behavioural PHY
  logic ph_en = 1'b0, ph_val = 1'b1, ta2_val = 1'b0, mdc_q = 1'b0;
  logic [15:0] regs [32];
  logic [15:0] out_sh;
  logic [31:0] fbits;
  int pos = 0, pre_run = 0, idle_run = 0, last_pre = -1, min_gap = 99, frames = 0;
  logic [1:0] last_op, last_ta, cur_op;
  logic [4:0] last_phy, last_reg, cur_phy, cur_reg;
  int done_cnt = 0, mdc_bad = 0, bus_bad = 0, mdc_run = 0;
  logic pmdc = 1'b0, po = 1'b0, poe = 1'b0;

  assign mdio_i = mdio_oe ? mdio_o : (ph_en ? ph_val : 1'b1);

  always @(negedge clk) begin
    if (!rst_n) begin
      pos = 0; ph_en = 1'b0; pre_run = 0; idle_run = 0; mdc_q = 1'b0;
    end else begin
      if (mdc && !mdc_q) begin
        if (pos == 0) begin
          if (!mdio_oe) begin idle_run++; pre_run = 0; end
          else if (mdio_o) pre_run++;
          else begin
            if (frames > 0 && idle_run < min_gap) min_gap = idle_run;
            last_pre = pre_run; pre_run = 0; idle_run = 0;
            fbits = 32'h0; pos = 1;
          end
        end else begin
          fbits = {fbits[30:0], mdio_i};
          pos++;
          if (pos == 14) begin
            cur_op = fbits[11:10]; cur_phy = fbits[9:5]; cur_reg = fbits[4:0];
          end
          if (pos == 15 && cur_op == 2'b10 && cur_phy == MYPHY) begin
            ph_en = 1'b1; ph_val = ta2_val; out_sh = regs[cur_reg];
          end
          if (pos >= 16 && pos <= 31 && ph_en) begin
            ph_val = out_sh[15]; out_sh = {out_sh[14:0], 1'b0};
          end
          if (pos == 32) begin
            ph_en = 1'b0; frames++;
            last_op = cur_op; last_phy = cur_phy; last_reg = cur_reg;
            last_ta = fbits[17:16];
            if (cur_op == 2'b01 && cur_phy == MYPHY) regs[cur_reg] = fbits[15:0];
            pos = 0;
          end
        end
      end
      mdc_q = mdc;
    end
  end

  // monitors for R1 and done counting
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (mdc != pmdc) begin
        if (mdc_run != CLK_DIV) mdc_bad++;
        mdc_run = 1;
      end else mdc_run++;
      if ((mdio_o != po || mdio_oe != poe) && !(pmdc && !mdc)) bus_bad++;
    end else mdc_run = 0;
    pmdc = mdc; po = mdio_o; poe = mdio_oe;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [15:0] got_data;
  logic got_err;
  int got_lat;

  task automatic do_req(input bit wr, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
    got_lat = 0;
    do begin
      @(negedge clk);
      got_lat++;
      if (got_lat == 1) req_valid = 1'b0;
    end while (!done);
    got_data = rd_data; got_err = rd_err;
  endtask

  task automatic do_reset(input logic [15:0] stat);
    regs[1] = stat;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(busy === 1'b1, "R6 busy in reset", busy, 1);
    check(mdio_oe === 1'b0, "R6 oe in reset", mdio_oe, 0);
    check(done === 1'b0, "R6 done in reset", done, 0);
    rst_n = 1'b1;
    done_cnt = 0;
    @(negedge clk);
    check(busy === 1'b1, "R6 busy after reset", busy, 1);
    while (busy) @(negedge clk);
    check(done_cnt == 0, "R6 no done for start-up", done_cnt, 0);
    check(last_pre == 32, "R6 start-up preamble", last_pre, 32);
    check(last_op == 2'b10 && last_reg == 5'd1 && last_phy == MYPHY,
          "R6 start-up read of reg 1", {last_op, last_phy, last_reg}, {2'b10, MYPHY, 5'd1});
  endtask

  // {write, reg, data, expected read}
  localparam int NV = 9;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 5'd5,  16'hA5C3, 16'h0000},
    {1'b0, 5'd5,  16'h0000, 16'hA5C3},
    {1'b1, 5'd31, 16'h0001, 16'h0000},
    {1'b0, 5'd31, 16'h0000, 16'h0001},
    {1'b1, 5'd0,  16'hFFFF, 16'h0000},
    {1'b0, 5'd0,  16'h0000, 16'hFFFF},
    {1'b1, 5'd12, 16'h8000, 16'h0000},
    {1'b0, 5'd12, 16'h0000, 16'h8000},
    {1'b0, 5'd20, 16'h0000, 16'h0000}
  };

  task automatic run_table(input int pre);
    for (int i = 0; i < NV; i++) begin
      logic wr; logic [4:0] rg; logic [15:0] wd, ex;
      {wr, rg, wd, ex} = VEC[i];
      do_req(wr, MYPHY, rg, wd);
      check(got_lat >= (pre + 33) * BIT_T + 1 && got_lat <= (pre + 34) * BIT_T + 1,
            "R10 done latency", got_lat, (pre + 33) * BIT_T + 1);
      check(last_pre == pre, "R7 preamble length", last_pre, pre);
      check(last_op == (wr ? 2'b01 : 2'b10) && last_reg == rg && last_phy == MYPHY,
            "R2 frame header", {last_op, last_phy, last_reg}, {(wr ? 2'b01 : 2'b10), MYPHY, rg});
      if (wr) begin
        check(regs[rg] == wd, "R2 write data", regs[rg], wd);
        check(last_ta == 2'b10, "R3 write turnaround", last_ta, 2'b10);
      end else begin
        check(got_data == ex, "R4 read data", got_data, ex);
        check(last_ta[0] == 1'b0, "R3 read turnaround released", last_ta, 0);
      end
      check(got_err == 1'b0, "R5 no error", got_err, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 16'h0000;
    @(negedge clk);
    // phase A: PHY does not allow suppression
    do_reset(16'h7809);
    run_table(32);
    check(min_gap >= 1, "R8 idle gap", min_gap, 1);

    // R9: request while busy ignored
    begin
      int f0;
      f0 = frames;
      while (busy) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_reg = 5'd5; req_phy = MYPHY;
      @(negedge clk); req_valid = 1'b0;
      repeat (10) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_reg = 5'd9; req_wdata = 16'h1234;
      @(negedge clk); req_valid = 1'b0;
      while (!done) @(negedge clk);
      repeat (3 * BIT_T) @(negedge clk);
      check(frames == f0 + 1, "R9 single frame", frames, f0 + 1);
      check(busy == 1'b0, "R9 no extra request", busy, 0);
      do_req(1'b0, MYPHY, 5'd9, 16'h0);
      check(got_data == 16'h0000, "R9 ignored write", got_data, 0);
    end

    // R5: absent PHY and bad turnaround
    do_req(1'b0, 5'h03, 5'd5, 16'h0);
    check(got_err == 1'b1, "R5 absent PHY error", got_err, 1);
    check(got_data == 16'hFFFF, "R5 absent PHY data", got_data, 16'hFFFF);
    ta2_val = 1'b1;
    do_req(1'b0, MYPHY, 5'd5, 16'h0);
    check(got_err == 1'b1, "R5 turnaround driven high", got_err, 1);
    ta2_val = 1'b0;
    do_req(1'b1, 5'h03, 5'd6, 16'h5555);
    check(got_err == 1'b0, "R5 write never errs", got_err, 0);

    // phase B: suppression advertised
    do_reset(16'h7849);
    run_table(0);
    do_req(1'b0, MYPHY, 5'd1, 16'h0);
    check(got_data == 16'h7849, "R4 status read", got_data, 16'h7849);
    check(min_gap >= 1, "R8 idle gap without preamble", min_gap, 1);

    // phase C: suppression bit set but start-up turnaround bad
    ta2_val = 1'b1;
    do_reset(16'h7849);
    ta2_val = 1'b0;
    do_req(1'b0, MYPHY, 5'd5, 16'h0);
    check(last_pre == 32, "R7 bad start-up keeps preamble", last_pre, 32);
    check(got_data == 16'hA5C3, "R4 read after bad start-up", got_data, 16'hA5C3);

    check(mdc_bad == 0, "R1 mdc half period", mdc_bad, 0);
    check(bus_bad == 0, "R1 bus moves on mdc fall", bus_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule